// File: doc/BRIEF.md
# Voted Binary-Search Probability Estimator

This block measures the density of ones in a unipolar stochastic bitstream and reports it as an N-bit binary number. A successive-approximation search replaces the slow linear up/down tracking loop. A base register holds the running guess. A step register holds the amount by which that guess moves next. Each search step lasts for a fixed observation window. Over that window the block counts the ones on the incoming stream. Three comparison lanes each turn the current guess into a bitstream of their own and count its ones.

Each lane has its own pseudo-random source, so its stream is independent of the other two. A lane votes up if its count is below the input count, votes down if its count is above the input count, and votes hold if the counts are equal. A two-of-three majority over the lane votes moves the guess. After each decision the step halves. A pulse on the start input launches a search. When the final unit step has been applied, a one-cycle flag announces the result.

Top module: `vote_prob_search`

## Requirements
- R1: While reset is asserted, and after it is released, the estimate output is 0 and the done flag is low until a search completes.
- R2: A start pulse seen while the block is idle loads the guess with 2^(N-1) and the step with 2^(N-2).
- R3: Each search step observes W consecutive cycles of the input stream. Every lane counts the ones it generates over the same W cycles, using a stream that is 1 when the top N bits of its 16-bit maximal-length LFSR are below the current guess.
- R4: A lane votes up when its generated count is below the input count, votes down when it is above, and votes hold when the two are equal. The guess moves only when at least two lanes agree on up, or at least two agree on down.
- R5: An up decision adds the step to the guess and a down decision subtracts it. The result saturates to the range 0 to 2^N-1. The guess does not change outside the initial load and the decision cycles.
- R6: The step halves after every decision, so a search makes N-1 decisions. The done flag rises exactly (N-1)*(W+1) clock edges after the edge that accepted the start pulse.
- R7: The done flag is high for exactly one cycle per search. The estimate output changes only in the cycle in which done is high, and it holds its value until the next search completes.
- R8: A start pulse during a running search is ignored. The search finishes at its original time and raises done once.
- R9: For an input stream that carries exactly k ones in every W consecutive cycles, the final estimate is near k*2^N/W. An all-ones input gives a result at the top of the range, and an all-zeros input gives a result at the bottom.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Starts a search when the block is idle |
| streamBit | input | 1 | One bit of the incoming unipolar stochastic stream per cycle |
| estimate | output | RES_BITS | Result of the most recent completed search |
| estDone | output | 1 | One-cycle pulse when a new estimate is available |

## Verification
The assertions assume a start pulse arrives only while the block is idle or is ignored by the block. They also assume the input stream carries one defined bit every cycle. The stimulus respects both. It raises start for a single cycle, and it produces the stream from a phase counter that visits every residue modulo W. Any W consecutive cycles therefore hold exactly the requested number of ones, whatever the offset between the stream and the search windows. This fixed density lets the bench know the true probability of each run and judge the result against a tolerance. The random part draws the densities, and the directed part covers the all-zeros and all-ones extremes and a start pulse issued mid-search.

// File: rtl/vps_pkg.sv
package vps_pkg;

  localparam int LFSR_W = 16;
  localparam int LANES  = 3;

  typedef struct packed {
    logic loadInit;
    logic accum;
    logic decide;
    logic publish;
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'b00,
    DIR_UP   = 2'b01,
    DIR_DOWN = 2'b10
  } dir_e;

  // x^16 + x^14 + x^13 + x^11 + 1, Fibonacci form
  function automatic logic [LFSR_W-1:0] lfsrNext(input logic [LFSR_W-1:0] cur);
    logic fb;
    fb = cur[15] ^ cur[13] ^ cur[12] ^ cur[10];
    return {cur[LFSR_W-2:0], fb};
  endfunction

endpackage

// File: rtl/vps_lane.sv
module vps_lane
  import vps_pkg::*;
#(
  parameter int RES_BITS = 8,
  parameter int CNT_W    = 9,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strb,
  input  logic [RES_BITS-1:0] baseVal,
  input  logic [CNT_W-1:0]    inCount,
  output dir_e                vote
);

  logic [LFSR_W-1:0] lfsrState;
  logic [CNT_W-1:0]  genCount;
  logic              genBit;

  // free-running source, never reaches the all-zero lock state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lfsrState <= SEED;
    else       lfsrState <= lfsrNext(lfsrState);
  end

  assign genBit = (lfsrState[LFSR_W-1 -: RES_BITS] < baseVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      genCount <= '0;
    end else if (strb.loadInit || strb.decide) begin
      genCount <= '0;
    end else if (strb.accum) begin
      genCount <= genCount + CNT_W'(genBit);
    end
  end

  always_comb begin
    if (genCount < inCount)      vote = DIR_UP;
    else if (genCount > inCount) vote = DIR_DOWN;
    else                         vote = DIR_HOLD;
  end

endmodule

// File: rtl/vps_datapath.sv
module vps_datapath
  import vps_pkg::*;
#(
  parameter int RES_BITS = 8,
  parameter int WIN_LEN  = 256,
  parameter logic [LANES-1:0][LFSR_W-1:0] LANE_SEEDS = {16'hACE1, 16'h5A3C, 16'h1F0D}
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strb,
  input  logic                streamBit,
  output logic [RES_BITS-1:0] estimate,
  output logic [RES_BITS-1:0] baseVal,
  output logic [RES_BITS-1:0] stepVal
);

  localparam int CNT_W = $clog2(WIN_LEN + 1);
  localparam logic [RES_BITS-1:0] BASE_INIT = RES_BITS'(1) << (RES_BITS - 1);
  localparam logic [RES_BITS-1:0] STEP_INIT = RES_BITS'(1) << (RES_BITS - 2);
  localparam logic [RES_BITS-1:0] BASE_MAX  = '1;

  logic [CNT_W-1:0]    inCount;
  logic [RES_BITS-1:0] baseReg, stepReg, nextBase;
  dir_e                laneVote [LANES];
  logic [1:0]          upVotes, downVotes;
  logic [RES_BITS:0]   upSum;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inCount <= '0;
    end else if (strb.loadInit || strb.decide) begin
      inCount <= '0;
    end else if (strb.accum) begin
      inCount <= inCount + CNT_W'(streamBit);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    vps_lane #(
      .RES_BITS(RES_BITS),
      .CNT_W   (CNT_W),
      .SEED    (LANE_SEEDS[g])
    ) u_lane (
      .clk     (clk),
      .rstN    (rstN),
      .strb    (strb),
      .baseVal (baseReg),
      .inCount (inCount),
      .vote    (laneVote[g])
    );
  end

  always_comb begin
    upVotes   = '0;
    downVotes = '0;
    for (int i = 0; i < LANES; i++) begin
      upVotes   = upVotes   + 2'((laneVote[i] == DIR_UP)   ? 1 : 0);
      downVotes = downVotes + 2'((laneVote[i] == DIR_DOWN) ? 1 : 0);
    end
  end

  assign upSum = {1'b0, baseReg} + {1'b0, stepReg};

  always_comb begin
    nextBase = baseReg;
    if (upVotes >= 2'd2) begin
      nextBase = upSum[RES_BITS] ? BASE_MAX : upSum[RES_BITS-1:0];
    end else if (downVotes >= 2'd2) begin
      nextBase = (baseReg < stepReg) ? '0 : (baseReg - stepReg);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseReg <= '0;
      stepReg <= '0;
    end else if (strb.loadInit) begin
      baseReg <= BASE_INIT;
      stepReg <= STEP_INIT;
    end else if (strb.decide) begin
      baseReg <= nextBase;
      stepReg <= stepReg >> 1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             estimate <= '0;
    else if (strb.publish) estimate <= nextBase;
  end

  assign baseVal = baseReg;
  assign stepVal = stepReg;

endmodule

// File: rtl/vps_control.sv
module vps_control
  import vps_pkg::*;
#(
  parameter int RES_BITS = 8,
  parameter int WIN_LEN  = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  output ctrlStrobe_t strb,
  output logic        estDone
);

  localparam int STEPS  = RES_BITS - 1;
  localparam int WIN_W  = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam int STEP_W = $clog2(STEPS + 1);
  localparam logic [WIN_W-1:0]  WIN_LAST  = WIN_W'(WIN_LEN - 1);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEPS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_OBSERVE, ST_DECIDE} state_e;

  state_e            state;
  logic [WIN_W-1:0]  winCnt;
  logic [STEP_W-1:0] stepIdx;
  logic              lastStep;

  assign lastStep = (stepIdx == STEP_LAST);

  always_comb begin
    strb          = '0;
    strb.loadInit = (state == ST_IDLE) && startReq;
    strb.accum    = (state == ST_OBSERVE);
    strb.decide   = (state == ST_DECIDE);
    strb.publish  = (state == ST_DECIDE) && lastStep;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      winCnt  <= '0;
      stepIdx <= '0;
      estDone <= 1'b0;
    end else begin
      estDone <= strb.publish;
      unique case (state)
        ST_IDLE: begin
          if (startReq) begin
            state   <= ST_OBSERVE;
            winCnt  <= '0;
            stepIdx <= '0;
          end
        end
        ST_OBSERVE: begin
          if (winCnt == WIN_LAST) state <= ST_DECIDE;
          else                    winCnt <= winCnt + 1'b1;
        end
        ST_DECIDE: begin
          winCnt <= '0;
          if (lastStep) begin
            state <= ST_IDLE;
          end else begin
            stepIdx <= stepIdx + 1'b1;
            state   <= ST_OBSERVE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vote_prob_search.sv
module vote_prob_search
  import vps_pkg::*;
#(
  parameter int RES_BITS = 8,
  parameter int WIN_LEN  = 256,
  parameter logic [LANES-1:0][LFSR_W-1:0] LANE_SEEDS = {16'hACE1, 16'h5A3C, 16'h1F0D}
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic                streamBit,
  output logic [RES_BITS-1:0] estimate,
  output logic                estDone
);

  ctrlStrobe_t         strb;
  logic [RES_BITS-1:0] baseVal;
  logic [RES_BITS-1:0] stepVal;

  vps_control #(
    .RES_BITS(RES_BITS),
    .WIN_LEN (WIN_LEN)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .strb     (strb),
    .estDone  (estDone)
  );

  vps_datapath #(
    .RES_BITS  (RES_BITS),
    .WIN_LEN   (WIN_LEN),
    .LANE_SEEDS(LANE_SEEDS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .streamBit(streamBit),
    .estimate (estimate),
    .baseVal  (baseVal),
    .stepVal  (stepVal)
  );

endmodule

// File: rtl/vps_checker.sv
module vps_checker
  import vps_pkg::*;
#(
  parameter int RES_BITS = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [RES_BITS-1:0] estimate,
  input logic                estDone,
  input ctrlStrobe_t         strb,
  input logic [RES_BITS-1:0] baseVal,
  input logic [RES_BITS-1:0] stepVal
);

  localparam logic [RES_BITS-1:0] BASE_INIT = RES_BITS'(1) << (RES_BITS - 1);
  localparam logic [RES_BITS-1:0] STEP_INIT = RES_BITS'(1) << (RES_BITS - 2);

  AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadInit |=> (baseVal == BASE_INIT) && (stepVal == STEP_INIT)); // R2

  AST_BASE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.loadInit || strb.decide) |=> $stable(baseVal)); // R5

  AST_STEP_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stepVal)); // R6

  AST_STEP_HALVES: assert property (@(posedge clk) disable iff (!rstN)
    strb.decide |=> stepVal == ($past(stepVal) >> 1)); // R6

  AST_DONE_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (!rstN)
    estDone |-> $past(strb.publish)); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    estDone |=> !estDone); // R7

  AST_EST_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(estimate) |-> estDone); // R7

endmodule

bind vote_prob_search vps_checker #(.RES_BITS(RES_BITS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .estimate (estimate),
  .estDone  (estDone),
  .strb     (strb),
  .baseVal  (baseVal),
  .stepVal  (stepVal)
);

// File: tb/vote_prob_search_bench.sv
module vote_prob_search_bench;

  localparam int CLK_PERIOD = 10;
  localparam int RES_BITS   = 8;
  localparam int WIN_LEN    = 256;
  localparam int FULL       = 1 << RES_BITS;
  localparam int TOL        = 24;
  localparam int WATCHDOG   = 190000;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                startReq = 1'b0;
  logic                streamBit = 1'b0;
  logic [RES_BITS-1:0] estimate;
  logic                estDone;

  int errors = 0;
  int checks = 0;
  int mode = 0;      // 0 all zeros, 1 all ones, 2 exact density
  int target = 0;    // ones per WIN_LEN cycles
  int phase = 0;
  bit finished = 1'b0;

  vote_prob_search #(.RES_BITS(RES_BITS), .WIN_LEN(WIN_LEN)) u_vote_prob_search (
    .clk(clk), .rstN(rstN), .startReq(startReq), .streamBit(streamBit),
    .estimate(estimate), .estDone(estDone)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // stream source: odd stride covers all residues in any WIN_LEN cycles
  initial begin
    forever begin
      @(negedge clk);
      phase = (phase + 1) % WIN_LEN;
      case (mode)
        0:       streamBit = 1'b0;
        1:       streamBit = 1'b1;
        default: streamBit = (((phase * 97) % WIN_LEN) < target);
      endcase
    end
  end

  function automatic int expLatency();
    return (RES_BITS - 1) * (WIN_LEN + 1);
  endfunction

  function automatic int idealEst(input int ones);
    int v;
    v = (ones * FULL) / WIN_LEN;
    if (v > FULL - 1) v = FULL - 1;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic printSummary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // runs one search; midStart > 0 pulses start again at that cycle count
  task automatic runSearch(input int midStart, output int est, output int lat, output int dones);
    int n;
    @(negedge clk); startReq = 1'b1;
    @(posedge clk);
    @(negedge clk); startReq = 1'b0;
    n = 0;
    dones = 0;
    while (!estDone && n < expLatency() + 50) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (estDone) dones++;
      if (midStart > 0 && n == midStart) startReq = 1'b1;
      else startReq = 1'b0;
    end
    startReq = 1'b0;
    lat = n;
    est = int'(estimate);
    // pulse must be gone next cycle, value must hold
    @(posedge clk); @(negedge clk);
    if (estDone) dones++;
    check(!estDone, "R7 done width", int'(estDone), 0);
    check(int'(estimate) == est, "R7 estimate hold", int'(estimate), est);
  endtask

  task automatic densityRun(input int ones, input string tag);
    int est, lat, dn, ideal, diff;
    mode = 2;
    target = ones;
    runSearch(0, est, lat, dn);
    ideal = idealEst(ones);
    diff = est - ideal;
    if (diff < 0) diff = -diff;
    check(diff <= TOL, tag, est, ideal);
    check(lat == expLatency(), "R6 latency", lat, expLatency());
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      printSummary();
      $finish;
    end
  end

  initial begin
    int est, lat, dn, seed;
    seed = $urandom(32'd1234);

    // R1: reset state
    repeat (3) @(negedge clk);
    check(estimate == '0, "R1 estimate in reset", int'(estimate), 0);
    check(!estDone, "R1 done in reset", int'(estDone), 0);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    check(estimate == '0, "R1 estimate after reset", int'(estimate), 0);
    check(!estDone, "R1 no done without start", int'(estDone), 0);

    // R9 / R5: all ones climbs to the top of the range
    mode = 1;
    runSearch(0, est, lat, dn);
    check(est >= FULL - 4, "R9 R5 all ones", est, FULL - 1);
    check(lat == expLatency(), "R6 latency all ones", lat, expLatency());
    check(dn == 1, "R7 one done pulse", dn, 1);

    // R9 / R5: all zeros falls to the bottom
    mode = 0;
    runSearch(0, est, lat, dn);
    check(est <= 3, "R9 R5 all zeros", est, 0);

    // R2: midpoint density stays near the initial guess
    densityRun(WIN_LEN / 2, "R2 R4 half density");
    densityRun(WIN_LEN / 4, "R3 R4 quarter density");
    densityRun(200, "R3 R4 density 200");
    densityRun(10, "R3 R4 low density");
    densityRun(WIN_LEN - 8, "R5 R4 near full density");

    // R8: a start during the search is ignored
    mode = 2;
    target = 90;
    runSearch(300, est, lat, dn);
    check(lat == expLatency(), "R8 latency with mid start", lat, expLatency());
    check(dn == 1, "R8 single done", dn, 1);
    repeat (WIN_LEN + 10) @(negedge clk);
    check(!estDone, "R8 no second search", int'(estDone), 0);

    // random densities
    for (int i = 0; i < 12; i++) begin
      densityRun(int'($urandom_range(0, WIN_LEN)), "R3 R4 R9 random density");
    end

    finished = 1'b1;
    printSummary();
    $finish;
  end

endmodule